// File: doc/BRIEF.md
# Serial Stereo Audio Receiver

This block takes stereo PCM audio from a three-wire serial link and turns it into one parallel stream beat per stereo frame. The three wires are a bit clock, a channel-select line and a data line. Each beat carries a left and a right sample, each 24 bits wide. Data is taken MSB first on rising bit-clock edges. The link pins are sampled in the system clock domain through a synchronizer, so the bit clock must stay well below the system clock.

The block can follow an external bit clock and channel-select (slave). It can also drive both itself (master). In master mode it divides the system clock down to a bit clock of 64 periods per stereo frame, and the data source follows the generated clocks. Static configuration inputs set the framing and the word length. The framing is either a one-bit-delayed framing (I2S) or an LSB-justified framing. The word length is 16, 20 or 24 bits.

The output is a valid/ready stream. A completed frame is loaded into a single output register when that register is empty or is being emptied in the same cycle. The register then stays valid, with stable data, until the consumer accepts it. A frame that completes while the register is still full and not accepted is discarded. Back-pressure therefore never stalls the serial side.

Top module: `sai_rx_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `out_valid`, `sclk_out` and `ws_out` are 0.
- R2: With `cfg_fmt`=0 (I2S), the first data bit of a channel word is the one taken on the second rising bit-clock edge at which the new channel-select level is seen. The word is taken MSB first, and the bits after the word length in the slot are ignored.
- R3: With `cfg_fmt`=1 (LSB-justified), the word is made of the last N bits taken before the rising edge at which the channel-select change is first seen. N is the word length, and earlier bits of the slot are ignored.
- R4: `cfg_wlen` selects the word length: 0 gives 16 bits, 1 gives 20 bits, and 2 or 3 give 24 bits. Each sample is sign-extended from its top received bit to 24 bits.
- R5: The data line is read only at rising bit-clock edges. Changes on it while the bit clock is high do not alter the received sample.
- R6: Channel-select low carries the left word and high carries the right word. A frame is emitted once after each right word that follows a completed left word. The partial word in progress when reception starts after reset is discarded.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_left`/`out_right` stay stable. A frame completing in that state is discarded. After a cycle with `out_valid` and `out_ready` both 1, and no new frame, `out_valid` is 0.
- R8: With `cfg_master`=1, `sclk_out` has a period of 2*(`cfg_div`+1) system clocks. `ws_out` changes only together with a falling `sclk_out` edge, once every 32 `sclk_out` periods. With `cfg_master`=0, both outputs are 0.
- R9: With `cfg_master`=1, the receiver is timed by its own generated clocks, and `sclk_in` and `ws_in` have no effect on the received samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1: generate bit clock and channel-select; 0: follow external ones |
| cfg_fmt | input | 1 | Framing: 0 = I2S, 1 = LSB-justified |
| cfg_wlen | input | 2 | Word length code: 0 = 16, 1 = 20, 2/3 = 24 bits |
| cfg_div | input | 8 | Master mode bit-clock half period minus one, in system clocks |
| sclk_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External channel-select (slave mode) |
| sd_in | input | 1 | Serial data |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated channel-select (master mode) |
| out_valid | output | 1 | Stereo frame available |
| out_ready | input | 1 | Consumer accepts the frame |
| out_left | output | 24 | Left sample, sign-extended |
| out_right | output | 24 | Right sample, sign-extended |

## Verification
A table of frames covers each framing at each word-length code, including the reserved code. The slot patterns are chosen so that every word has set bits on both sides of the word boundary. This separates MSB-side capture from LSB-side capture, and a 16-bit window from a 20-bit or 24-bit one. Each length also has samples with both sign values, which exposes a wrong sign bit. One frame toggles the data line during the high phase of every bit clock, which shows whether the data is read at the rising edge or later. Directed runs hold off the consumer across two frames to show that the second frame is discarded. A master-mode run times the generated clocks while the external clock pins toggle at random.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int LEN_W    = 6;

  typedef enum logic [1:0] {
    WLEN_16  = 2'd0,
    WLEN_20  = 2'd1,
    WLEN_24  = 2'd2,
    WLEN_24X = 2'd3
  } wlen_e;

  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_LSBJ = 1'b1
  } fmt_e;

  function automatic logic [LEN_W-1:0] wlen_bits(input wlen_e w);
    case (w)
      WLEN_16: wlen_bits = LEN_W'(16);
      WLEN_20: wlen_bits = LEN_W'(20);
      default: wlen_bits = LEN_W'(SAMPLE_W);
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] sign_fit(input logic [SAMPLE_W-1:0] v,
                                                   input wlen_e w);
    case (w)
      WLEN_16: sign_fit = {{(SAMPLE_W-16){v[15]}}, v[15:0]};
      WLEN_20: sign_fit = {{(SAMPLE_W-20){v[19]}}, v[19:0]};
      default: sign_fit = v;
    endcase
  endfunction

endpackage

// File: rtl/sai_rx_pin_sync.sv
module sai_rx_pin_sync #(
  parameter int STAGES = 2,
  parameter int PINS   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_raw,
  output logic [PINS-1:0] pin_sync,
  output logic            pin0_rise
);

  logic [PINS-1:0] chain [STAGES];
  logic            pin0_last;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) pin0_last <= 1'b0;
    else        pin0_last <= chain[STAGES-1][0];
  end

  assign pin_sync  = chain[STAGES-1];
  assign pin0_rise = chain[STAGES-1][0] & ~pin0_last;

endmodule

// File: rtl/sai_rx_clkgen.sv
module sai_rx_clkgen #(
  parameter int DIV_W      = 8,
  parameter int FRAME_BITS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk_gen,
  output logic             ws_gen
);

  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] bit_nxt;

  assign bit_nxt = bit_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      div_cnt  <= '0;
      bit_cnt  <= '0;
      sclk_gen <= 1'b0;
      ws_gen   <= 1'b0;
    end else if (div_cnt == half_div) begin
      div_cnt  <= '0;
      sclk_gen <= ~sclk_gen;
      if (sclk_gen) begin
        bit_cnt <= bit_nxt;
        ws_gen  <= bit_nxt[CNT_W-1];
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  AST_WS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_gen != $past(ws_gen)) |-> $fell(sclk_gen)); // R8

  AST_SLAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sclk_gen && !ws_gen)); // R8

endmodule

// File: rtl/sai_rx_deser.sv
module sai_rx_deser
  import sai_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic                ws_bit,
  input  logic                sd_bit,
  input  fmt_e                fmt,
  input  wlen_e               wlen,
  output logic                frame_stb,
  output logic [SAMPLE_W-1:0] frame_left,
  output logic [SAMPLE_W-1:0] frame_right
);

  logic                primed;
  logic                aligned;
  logic                ws_prev;
  logic                left_ok;
  logic [LEN_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] cap;
  logic [SAMPLE_W-1:0] shr;
  logic [SAMPLE_W-1:0] left_hold;

  logic [LEN_W-1:0]    wl_n;
  logic                room;
  logic                ws_edge;
  logic [SAMPLE_W-1:0] raw;
  logic [SAMPLE_W-1:0] word;

  always_comb begin
    wl_n    = wlen_bits(wlen);
    room    = (cnt < wl_n);
    ws_edge = primed && (ws_bit != ws_prev);
    if (fmt == FMT_I2S) raw = room ? {cap[SAMPLE_W-2:0], sd_bit} : cap;
    else                raw = shr;
    word = sign_fit(raw, wlen);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed      <= 1'b0;
      aligned     <= 1'b0;
      ws_prev     <= 1'b0;
      left_ok     <= 1'b0;
      cnt         <= '0;
      cap         <= '0;
      shr         <= '0;
      left_hold   <= '0;
      frame_stb   <= 1'b0;
      frame_left  <= '0;
      frame_right <= '0;
    end else begin
      frame_stb <= 1'b0;
      if (bit_stb) begin
        shr <= {shr[SAMPLE_W-2:0], sd_bit};
        if (!primed) begin
          primed  <= 1'b1;
          ws_prev <= ws_bit;
        end else if (ws_edge) begin
          ws_prev <= ws_bit;
          cnt     <= '0;
          cap     <= '0;
          aligned <= 1'b1;
          if (aligned) begin
            if (!ws_prev) begin
              left_hold <= word;
              left_ok   <= 1'b1;
            end else if (left_ok) begin
              frame_left  <= left_hold;
              frame_right <= word;
              frame_stb   <= 1'b1;
              left_ok     <= 1'b0;
            end
          end
        end else if (room) begin
          cap <= {cap[SAMPLE_W-2:0], sd_bit};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb); // R6

  AST_SIGN_FIT_16: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && wlen == WLEN_16) |->
      ($countones(frame_right[SAMPLE_W-1:15]) == 0 ||
       $countones(frame_right[SAMPLE_W-1:15]) == SAMPLE_W-15)); // R4

endmodule

// File: rtl/sai_rx_top.sv
module sai_rx_top
  import sai_rx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic                cfg_fmt,
  input  logic [1:0]          cfg_wlen,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                sclk_in,
  input  logic                ws_in,
  input  logic                sd_in,
  output logic                sclk_out,
  output logic                ws_out,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);

  logic [2:0]          pin_raw;
  logic [2:0]          pin_sync;
  logic                bclk_rise;
  logic                frame_stb;
  logic [SAMPLE_W-1:0] frame_left;
  logic [SAMPLE_W-1:0] frame_right;
  logic                take;

  sai_rx_clkgen #(.DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg_master),
    .half_div (cfg_div),
    .sclk_gen (sclk_out),
    .ws_gen   (ws_out)
  );

  assign pin_raw = {sd_in,
                    cfg_master ? ws_out   : ws_in,
                    cfg_master ? sclk_out : sclk_in};

  sai_rx_pin_sync #(.STAGES(SYNC_STAGES), .PINS(3)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_raw   (pin_raw),
    .pin_sync  (pin_sync),
    .pin0_rise (bclk_rise)
  );

  sai_rx_deser u_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb     (bclk_rise),
    .ws_bit      (pin_sync[1]),
    .sd_bit      (pin_sync[2]),
    .fmt         (fmt_e'(cfg_fmt)),
    .wlen        (wlen_e'(cfg_wlen)),
    .frame_stb   (frame_stb),
    .frame_left  (frame_left),
    .frame_right (frame_right)
  );

  assign take = frame_stb && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_left  <= frame_left;
      out_right <= frame_right;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_left) && $stable(out_right))); // R7

  AST_FRAME_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !out_valid) |=> out_valid); // R6

endmodule

// File: tb/sim_sai_rx_top.sv
`timescale 1ns/1ps
module sim_sai_rx_top;

  typedef struct packed {
    logic        fmt;
    logic [1:0]  wl;
    logic        noisy;
    logic [31:0] sl;
    logic [31:0] sr;
    logic [23:0] el;
    logic [23:0] er;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd2, 1'b0, 32'h123456AA, 32'hFEDCBA55, 24'h123456, 24'hFEDCBA},
    '{1'b0, 2'd0, 1'b0, 32'h8001FFFF, 32'h7FFE0000, 24'hFF8001, 24'h007FFE},
    '{1'b0, 2'd1, 1'b0, 32'hABCDE123, 32'h12345FFF, 24'hFABCDE, 24'h012345},
    '{1'b1, 2'd2, 1'b1, 32'hFF654321, 32'h00876543, 24'h654321, 24'h876543},
    '{1'b1, 2'd0, 1'b0, 32'hDEAD1234, 32'h0000C000, 24'h001234, 24'hFFC000},
    '{1'b1, 2'd1, 1'b0, 32'hFFF7FFFF, 32'h00080000, 24'h07FFFF, 24'hF80000},
    '{1'b0, 2'd3, 1'b0, 32'h80000000, 32'h000001FF, 24'h800000, 24'h000001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b0;
  logic        cfg_fmt = 1'b0;
  logic [1:0]  cfg_wlen = 2'd2;
  logic [7:0]  cfg_div = 8'd3;
  logic        sclk_in = 1'b0;
  logic        ws_in = 1'b0;
  logic        sd_in = 1'b0;
  logic        sclk_out;
  logic        ws_out;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_left;
  logic [23:0] out_right;

  int errors = 0;
  int checks = 0;
  int hs_total = 0;
  int cyc = 0;
  logic [23:0] cap_l = '0;
  logic [23:0] cap_r = '0;

  always #10 clk = ~clk;

  sai_rx_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt(cfg_fmt),
    .cfg_wlen(cfg_wlen), .cfg_div(cfg_div), .sclk_in(sclk_in), .ws_in(ws_in),
    .sd_in(sd_in), .sclk_out(sclk_out), .ws_out(ws_out), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      hs_total <= hs_total + 1;
      cap_l    <= out_left;
      cap_r    <= out_right;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic do_reset();
    sclk_in = 1'b0;
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic ws, input logic b, input bit noisy);
    sclk_in = 1'b0;
    ws_in   = ws;
    sd_in   = b;
    tick(5);
    sclk_in = 1'b1;
    tick(3);
    if (noisy) sd_in = ~b;
    tick(2);
  endtask

  task automatic send_slot(input logic fmt, input logic ch, input logic nxt,
                           input logic [31:0] s, input bit noisy);
    for (int t = 0; t < 32; t++)
      send_bit((fmt == 1'b0 && t == 31) ? nxt : ch, s[31-t], noisy);
  endtask

  task automatic run_master();
    logic [31:0] sl = 32'h00ABCDEF;
    logic [31:0] sr = 32'h0013579B;
    logic        prev_s;
    logic        prev_w;
    int          t;
    int          base;
    int          t0;
    int          rises;
    cfg_master = 1'b1; cfg_fmt = 1'b1; cfg_wlen = 2'd2; cfg_div = 8'd3;
    do_reset();
    // R8: bit clock period = 2*(3+1) system clocks
    while (sclk_out !== 1'b0) tick(1);
    while (sclk_out !== 1'b1) tick(1);
    t0 = cyc;
    tick(1);
    while (sclk_out !== 1'b0) tick(1);
    while (sclk_out !== 1'b1) tick(1);
    check(cyc - t0 == 8, "R8 sclk_out period", cyc - t0, 8);
    // R8: ws_out changes every 32 bit clock periods
    prev_w = ws_out;
    while (ws_out === prev_w) tick(1);
    prev_w = ws_out;
    prev_s = sclk_out;
    rises = 0;
    while (ws_out === prev_w) begin
      tick(1);
      if (!prev_s && sclk_out) rises++;
      prev_s = sclk_out;
    end
    check(rises == 32, "R8 ws_out interval", rises, 32);
    // R9: receive from own clocks while external pins toggle
    base = hs_total;
    t = 0;
    prev_s = sclk_out;
    prev_w = ws_out;
    for (int i = 0; i < 4000; i++) begin
      tick(1);
      if (i % 3 == 0) sclk_in = ~sclk_in;
      ws_in = 1'($urandom);
      if (prev_s && !sclk_out) begin
        if (ws_out != prev_w) t = 0;
        else t = (t + 1) % 32;
        sd_in = ws_out ? sr[31-t] : sl[31-t];
        prev_w = ws_out;
      end
      prev_s = sclk_out;
    end
    tick(2);
    check(hs_total - base >= 2, "R9 master frames", hs_total - base, 2);
    check(cap_l == 24'hABCDEF, "R9 master left", cap_l, 24'hABCDEF);
    check(cap_r == 24'h13579B, "R9 master right", cap_r, 24'h13579B);
    cfg_master = 1'b0;
  endtask

  initial begin
    int base;
    tick(2);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(sclk_out == 1'b0 && ws_out == 1'b0, "R1 clock outputs in reset",
          {sclk_out, ws_out}, 0);
    rst_n = 1'b1;
    tick(1);
    check(out_valid == 1'b0, "R1 out_valid after release", out_valid, 0);

    // Table walk: R2 (I2S), R3 (LSB-justified), R4 (lengths), R5 (noise), R6
    for (int v = 0; v < NV; v++) begin
      cfg_fmt  = VEC[v].fmt;
      cfg_wlen = VEC[v].wl;
      do_reset();
      base = hs_total;
      send_slot(VEC[v].fmt, 1'b1, 1'b0, 32'h0, 1'b0);
      send_slot(VEC[v].fmt, 1'b0, 1'b1, VEC[v].sl, VEC[v].noisy);
      send_slot(VEC[v].fmt, 1'b1, 1'b0, VEC[v].sr, VEC[v].noisy);
      send_slot(VEC[v].fmt, 1'b0, 1'b1, 32'h0, 1'b0);
      send_slot(VEC[v].fmt, 1'b1, 1'b1, 32'h0, 1'b0);
      tick(4);
      check(hs_total - base == 1, "R6 one frame per vector", hs_total - base, 1);
      check(cap_l == VEC[v].el, VEC[v].fmt ? "R3/R4 left word" : "R2/R4 left word",
            cap_l, VEC[v].el);
      check(cap_r == VEC[v].er, VEC[v].noisy ? "R5 right word under noise" :
            (VEC[v].fmt ? "R3/R4 right word" : "R2/R4 right word"),
            cap_r, VEC[v].er);
      if (v == 0)
        check(sclk_out == 1'b0 && ws_out == 1'b0, "R8 slave outputs idle",
              {sclk_out, ws_out}, 0);
    end

    // R7: back-pressure holds the first frame and drops the second
    cfg_fmt = 1'b0; cfg_wlen = 2'd2;
    out_ready = 1'b0;
    do_reset();
    base = hs_total;
    send_slot(1'b0, 1'b1, 1'b0, 32'h0, 1'b0);
    send_slot(1'b0, 1'b0, 1'b1, 32'h11111100, 1'b0);
    send_slot(1'b0, 1'b1, 1'b0, 32'h22222200, 1'b0);
    send_slot(1'b0, 1'b0, 1'b1, 32'h33333300, 1'b0);
    send_slot(1'b0, 1'b1, 1'b0, 32'h44444400, 1'b0);
    send_slot(1'b0, 1'b0, 1'b1, 32'h0, 1'b0);
    tick(4);
    check(out_valid == 1'b1, "R7 valid held", out_valid, 1);
    check(out_left == 24'h111111, "R7 held left", out_left, 24'h111111);
    check(out_right == 24'h222222, "R7 held right", out_right, 24'h222222);
    out_ready = 1'b1;
    tick(3);
    check(out_valid == 1'b0, "R7 valid cleared after accept", out_valid, 0);
    check(hs_total - base == 1, "R7 second frame dropped", hs_total - base, 1);
    check(cap_r == 24'h222222, "R7 accepted right", cap_r, 24'h222222);

    run_master();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

endmodule